// File: doc/BRIEF.md
# Flash Read Accelerator

This block sits between a 32-bit CPU fetch/load port and one flash array that returns a 128-bit line per read. It keeps three one-line buffers: a prefetch line, a branch-target line and a data line. Each buffer has its own tag and comparator. A 4:1 word selector picks the requested 32-bit word out of the chosen line. In the buffering modes it also reads ahead. Once the flash array goes idle after an instruction fetch, it starts reading the line that follows the one the CPU is executing from. The CPU then finds sequential code ready or nearly ready.

A small configuration port sets the operating mode and the flash access time in CPU clocks. The flash controller signals the start of a program or erase with a one-cycle pulse and raises a busy level while the array is unavailable. The accelerator empties its buffers on that pulse and stalls the CPU for as long as the array is busy.

The CPU presents a request and holds the address and qualifiers until the wait output drops. The read word is valid in the cycle where a request is present and wait is low.

Top module: `flash_read_accel`

## Requirements
- R1: After reset the mode reads 00, the access time reads 7, wait is low with no request, and no flash read is issued.
- R2: A mode write (select 0) takes `cfg_wdata[1:0]`, and the value 11 is ignored. A timing write (select 1) takes `cfg_wdata[2:0]`, and the value 000 is ignored. Both fields read back on `cfg_mode` and `cfg_time`.
- R3: In mode 00 every request sees exactly T wait cycles, where T is the access time. No buffer is used and flash is never read without a pending CPU request.
- R4: Address bits [3:2] select the word, so word k of a line is bits [32k+31:32k]. Addresses are word aligned.
- R5: In mode 10 an instruction request that hits the prefetch or branch buffer, or a data request that hits the data buffer, completes with zero wait cycles. A miss costs T wait cycles.
- R6: In mode 01 only sequential instruction fetches may hit, and they hit with zero wait. Non-sequential fetches and all data reads take T wait cycles even when the line is buffered.
- R7: In modes 01 and 10, one cycle after the flash array goes idle, a read of the line after the last fetched instruction line begins, unless that line is already held.
- R8: A fetch of the read-ahead line is served with zero wait if the read has finished. If the read is still running, the fetch waits only for the cycles that remain.
- R9: A completed read-ahead line is discarded when an instruction fetch to any other line arrives. A later fetch of it costs the full T.
- R10: A data miss, or a non-matching instruction miss, aborts a read-ahead in flight. The read-ahead restarts after the demand read completes.
- R11: A non-sequential instruction miss loads the branch buffer, and later fetches from that line hit in it.
- R12: A legal mode write invalidates all three buffers and any pending read-ahead line.
- R13: A program/erase start pulse invalidates all buffers. While the busy input is high, requests wait and no flash read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the mode field, 1 the timing field |
| cfg_wdata | input | 3 | Configuration write value |
| cfg_mode | output | 2 | Current mode |
| cfg_time | output | 3 | Current flash access time in clocks |
| cpu_req | input | 1 | CPU read request, held until wait drops |
| cpu_addr | input | AW | CPU byte address |
| cpu_instr | input | 1 | 1 for an instruction fetch, 0 for a data read |
| cpu_seq | input | 1 | 1 when the fetch follows the previous one in sequence |
| cpu_rdata | output | 32 | Read word |
| cpu_wait | output | 1 | CPU stall |
| fl_req | output | 1 | Flash read in progress |
| fl_addr | output | AW-4 | Flash line address |
| fl_rdata | input | 128 | Flash line read data |
| pe_start | input | 1 | Program/erase start pulse |
| fl_busy | input | 1 | Flash array busy with program/erase |

## Verification
The embedded properties take it as given that the CPU holds request, address and qualifiers steady while wait is high, that addresses are word aligned, and that the busy level only appears together with or after a program/erase start pulse. The bench keeps to this. Every request goes through one driver task that raises the request just after a clock edge and changes nothing until it sees wait low at a falling edge. The program/erase pulse and the busy level are only ever raised in the same cycle. Expected wait counts were worked out cycle by cycle for each scenario, so the timing of read-ahead, abort and restart can be observed at the ports.

// File: rtl/flash_read_accel.sv
module flash_read_accel #(
  parameter int AW  = 16,
  parameter int WW  = 32,
  parameter int WPL = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic                 cfg_sel,
  input  logic [2:0]           cfg_wdata,
  output logic [1:0]           cfg_mode,
  output logic [2:0]           cfg_time,
  input  logic                 cpu_req,
  input  logic [AW-1:0]        cpu_addr,
  input  logic                 cpu_instr,
  input  logic                 cpu_seq,
  output logic [WW-1:0]        cpu_rdata,
  output logic                 cpu_wait,
  output logic                 fl_req,
  output logic [AW-$clog2(WW*WPL/8)-1:0] fl_addr,
  input  logic [WW*WPL-1:0]    fl_rdata,
  input  logic                 pe_start,
  input  logic                 fl_busy
);
  localparam int LINEW = WW * WPL;
  localparam int BL    = $clog2(WW / 8);
  localparam int OFS   = $clog2(LINEW / 8);
  localparam int WS    = $clog2(WPL);
  localparam int LW    = AW - OFS;
  localparam int NB    = 3;

  logic [1:0]       mode;
  logic [2:0]       tim;
  logic [NB-1:0]    bv;
  logic [LW-1:0]    btag [NB];
  logic [LINEW-1:0] bdat [NB];
  logic             plat_v;
  logic [LW-1:0]    plat_tag;
  logic [LINEW-1:0] plat_dat;
  logic             eng_busy, eng_pf;
  logic [2:0]       eng_cnt;
  logic [LW-1:0]    eng_line;
  logic             cur_v;
  logic [LW-1:0]    cur_line;

  wire [LW-1:0] rline = cpu_addr[AW-1:OFS];
  wire [WS-1:0] rword = cpu_addr[OFS-1:BL];
  wire [LW-1:0] tgt   = cur_line + LW'(1);

  wire full  = (mode == 2'b10);
  wire part  = (mode == 2'b01);
  wire qual  = full || (part && cpu_instr && cpu_seq);

  logic [NB-1:0] hit, thit;
  for (genvar b = 0; b < NB; b++) begin : g_cmp
    assign hit[b]  = bv[b] && (btag[b] == rline);
    assign thit[b] = bv[b] && (btag[b] == tgt);
  end

  wire ibuf      = qual && cpu_instr && (hit[0] || hit[1]);
  wire dbuf      = full && !cpu_instr && hit[2];
  wire plat_hit  = qual && cpu_instr && plat_v && (plat_tag == rline);
  wire eng_done  = eng_busy && (eng_cnt == 3'd1);
  wire eng_match = eng_busy && (eng_line == rline) && (!eng_pf || (qual && cpu_instr));
  wire go        = cpu_req && !fl_busy;
  wire serve     = go && (ibuf || dbuf || plat_hit || (eng_match && eng_done));
  wire launch_dem = go && !(ibuf || dbuf || plat_hit || eng_match);
  wire tgt_have  = thit[0] || thit[1] || (plat_v && plat_tag == tgt);
  wire launch_pf = (full || part) && !fl_busy && !eng_busy && cur_v && !tgt_have && !launch_dem;

  wire mode_wr = cfg_wr && !cfg_sel && (cfg_wdata[1:0] != 2'b11);
  wire time_wr = cfg_wr && cfg_sel && (cfg_wdata != 3'd0);
  wire inval   = pe_start || mode_wr;

  wire fill_en = serve && !(ibuf || dbuf);
  wire [1:0] fill_idx = (plat_hit || (cpu_instr && (cpu_seq || eng_pf))) ? 2'd0 :
                        cpu_instr ? 2'd1 : 2'd2;
  wire [LINEW-1:0] fill_dat = plat_hit ? plat_dat : fl_rdata;
  wire other_ifetch = cpu_req && cpu_instr;
  wire plat_drop = (other_ifetch && plat_v && plat_tag != rline) || (serve && plat_hit);
  wire plat_store = eng_done && eng_pf && !fl_busy && !(serve && eng_match) &&
                    !(other_ifetch && rline != eng_line);

  logic [LINEW-1:0] src;
  always_comb begin
    if (ibuf)          src = hit[0] ? bdat[0] : bdat[1];
    else if (dbuf)     src = bdat[2];
    else if (plat_hit) src = plat_dat;
    else               src = fl_rdata;
  end

  logic [WW-1:0] words [WPL];
  for (genvar g = 0; g < WPL; g++) begin : g_word
    assign words[g] = src[g*WW +: WW];
  end

  assign cpu_rdata = words[rword];
  assign cpu_wait  = cpu_req && !serve;
  assign fl_req    = eng_busy;
  assign fl_addr   = eng_line;
  assign cfg_mode  = mode;
  assign cfg_time  = tim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= 2'b00;  tim <= 3'd7;
      bv <= '0;  plat_v <= 1'b0;  plat_tag <= '0;  plat_dat <= '0;
      eng_busy <= 1'b0;  eng_pf <= 1'b0;  eng_cnt <= '0;  eng_line <= '0;
      cur_v <= 1'b0;  cur_line <= '0;
      for (int b = 0; b < NB; b++) begin btag[b] <= '0; bdat[b] <= '0; end
    end else begin
      if (mode_wr) mode <= cfg_wdata[1:0];
      if (time_wr) tim  <= cfg_wdata;

      if (launch_dem) begin
        eng_busy <= 1'b1; eng_pf <= 1'b0; eng_cnt <= tim; eng_line <= rline;
      end else if (eng_done) begin
        eng_busy <= 1'b0;
      end else if (launch_pf) begin
        eng_busy <= 1'b1; eng_pf <= 1'b1; eng_cnt <= tim; eng_line <= tgt;
      end else if (eng_busy) begin
        eng_cnt <= eng_cnt - 3'd1;
      end

      if (plat_drop) plat_v <= 1'b0;
      if (plat_store) begin
        plat_v <= 1'b1; plat_tag <= eng_line; plat_dat <= fl_rdata;
      end

      if (fill_en) begin
        bv[fill_idx] <= 1'b1; btag[fill_idx] <= rline; bdat[fill_idx] <= fill_dat;
      end

      if (serve && cpu_instr) begin cur_v <= 1'b1; cur_line <= rline; end

      if (fl_busy) eng_busy <= 1'b0;
      if (inval) begin
        bv <= '0; plat_v <= 1'b0; cur_v <= 1'b0; eng_busy <= 1'b0;
      end
    end
  end

  p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> cpu_addr[BL-1:0] == '0);

  p_off_from_flash_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && cpu_req && !cpu_wait) |-> (fl_req && fl_addr == rline));

  p_off_no_readahead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && fl_req) |-> cpu_req);

  p_busy_holds_cpu_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && fl_busy) |-> cpu_wait);

  p_busy_no_flash_r13: assert property (@(posedge clk) disable iff (!rst_n)
    fl_busy |=> !fl_req);

  p_inval_forces_wait_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pe_start || (cfg_wr && !cfg_sel && cfg_wdata[1:0] != 2'b11)) && cpu_req) |-> cpu_wait);
endmodule

// File: tb/flash_read_accel_test.sv
`timescale 1ns/100ps
module flash_read_accel_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, cfg_sel = 0;
  logic [2:0] cfg_wdata = 0;
  logic [1:0] cfg_mode;
  logic [2:0] cfg_time;
  logic cpu_req = 0, cpu_instr = 0, cpu_seq = 0;
  logic [15:0] cpu_addr = 0;
  logic [31:0] cpu_rdata;
  logic cpu_wait, fl_req;
  logic [11:0] fl_addr;
  logic [127:0] fl_rdata;
  logic pe_start = 0, fl_busy = 0;

  int nchk = 0, nfail = 0, wcnt = 0;
  bit ended = 0;
  int exp_w[$];
  logic [31:0] exp_d[$];
  string exp_t[$];

  always #2.5 clk = ~clk;

  flash_read_accel uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_mode(cfg_mode), .cfg_time(cfg_time), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_instr(cpu_instr), .cpu_seq(cpu_seq), .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait),
    .fl_req(fl_req), .fl_addr(fl_addr), .fl_rdata(fl_rdata), .pe_start(pe_start),
    .fl_busy(fl_busy));

  function automatic logic [31:0] wval(logic [11:0] ln, int k);
    return 32'h5A00_0000 | (32'(ln) << 8) | 32'(k);
  endfunction

  always_comb
    for (int k = 0; k < 4; k++) fl_rdata[k*32 +: 32] = wval(fl_addr, k);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cpu_req) begin
      if (cpu_wait) wcnt++;
      else if (exp_w.size() == 0) chk("R1 unexpected completion", 32'd1, 32'd0);
      else begin
        chk({exp_t[0], " waits"}, 32'(wcnt), 32'(exp_w[0]));
        chk({exp_t[0], " data"}, cpu_rdata, exp_d[0]);
        void'(exp_w.pop_front()); void'(exp_d.pop_front()); void'(exp_t.pop_front());
        wcnt = 0;
      end
    end
  end

  task automatic acc(logic [15:0] a, logic ins, logic sq, int waits, string tag);
    @(posedge clk); #1;
    cpu_req = 1; cpu_addr = a; cpu_instr = ins; cpu_seq = sq;
    exp_w.push_back(waits); exp_d.push_back(wval(a[15:4], int'(a[3:2]))); exp_t.push_back(tag);
    forever begin
      @(negedge clk);
      if (!cpu_wait) break;
    end
  endtask

  task automatic idle(int n, bit look);
    repeat (n) begin
      @(posedge clk); #1 cpu_req = 0;
      if (look) begin @(negedge clk); chk("R3 no idle flash read", 32'(fl_req), 32'd0); end
    end
  endtask

  task automatic cfg_write(logic sel, logic [2:0] v);
    @(posedge clk); #1 cpu_req = 0; cfg_wr = 1; cfg_sel = sel; cfg_wdata = v;
    @(posedge clk); #1 cfg_wr = 0;
  endtask

  initial begin
    repeat (6000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog: actual hung expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 mode", 32'(cfg_mode), 32'd0);
    chk("R1 time", 32'(cfg_time), 32'd7);
    chk("R1 wait", 32'(cpu_wait), 32'd0);
    chk("R1 flash idle", 32'(fl_req), 32'd0);
    acc(16'h0080, 1, 0, 7, "R3 default time");

    cfg_write(0, 3'b011); @(negedge clk); chk("R2 mode 11 ignored", 32'(cfg_mode), 32'd0);
    cfg_write(1, 3'b000); @(negedge clk); chk("R2 time 000 ignored", 32'(cfg_time), 32'd7);
    cfg_write(1, 3'd3);   @(negedge clk); chk("R2 time write", 32'(cfg_time), 32'd3);
    cfg_write(0, 3'b010); @(negedge clk); chk("R2 mode write", 32'(cfg_mode), 32'd2);

    acc(16'h0100, 1, 0, 3, "R11 branch miss");
    acc(16'h0104, 1, 1, 0, "R11 branch buffer hit R4");
    idle(1, 0);
    acc(16'h0110, 1, 1, 1, "R8 in-flight match R7");
    acc(16'h0114, 1, 1, 0, "R5 prefetch buffer hit");
    idle(4, 0);
    acc(16'h0128, 1, 1, 0, "R8 completed read-ahead R4");
    idle(4, 0);
    acc(16'h0200, 1, 0, 3, "R9 other line");
    acc(16'h0130, 1, 1, 3, "R9 discarded line");
    acc(16'h0300, 0, 0, 3, "R5 data miss");
    acc(16'h0304, 0, 0, 0, "R5 data hit");
    acc(16'h0400, 0, 0, 3, "R10 data miss aborts");
    idle(1, 0);
    acc(16'h0140, 1, 1, 2, "R10 read-ahead restarted");
    acc(16'h040C, 0, 0, 0, "R5 data hit R4");

    cfg_write(0, 3'b010);
    acc(16'h0408, 0, 0, 3, "R12 invalidated");

    @(posedge clk); #1 cpu_req = 0; pe_start = 1; fl_busy = 1;
    fork
      begin @(posedge clk); #1 pe_start = 0; end
      begin repeat (4) @(posedge clk); #1 fl_busy = 0; end
      begin @(posedge clk); @(negedge clk); chk("R13 no flash read when busy", 32'(fl_req), 32'd0); end
    join_none
    acc(16'h0400, 0, 0, 6, "R13 busy then miss");

    cfg_write(0, 3'b001);
    acc(16'h0500, 1, 0, 3, "R6 partial branch miss");
    acc(16'h0504, 1, 1, 0, "R6 partial sequential hit");
    acc(16'h0508, 1, 0, 3, "R6 partial non-sequential");
    acc(16'h0600, 0, 0, 3, "R6 partial data");
    acc(16'h0604, 0, 0, 3, "R6 partial data again");

    cfg_write(1, 3'd2);
    cfg_write(0, 3'b000);
    acc(16'h0700, 1, 0, 2, "R3 off non-sequential");
    acc(16'h0704, 1, 1, 2, "R3 off sequential");
    acc(16'h0708, 0, 0, 2, "R3 off data");
    idle(3, 1);
    cfg_write(1, 3'd1);
    acc(16'h070C, 1, 1, 1, "R3 one clock");
    idle(2, 0);
    chk("R1 scoreboard drained", 32'(exp_w.size()), 32'd0);
    finish_up();
  end
endmodule